// File: doc/BRIEF.md
# Warp Engine Command-Token Sequencer

This block sits at the command input of an image warping engine. It takes 32-bit tokens, one per cycle, over a valid/ready handshake. Each token is either a register-configure command or an unaddressed data token. A configure token names one of 27 parameter registers and writes a value to it. Data tokens carry no address. A small sequencer places each data token into the next register of a fixed run, and the run depends on the processing mode. The short run for scaling mode is three tokens. The long run for tetragon mode is ten tokens and covers the four corner points and the two addresses.

When the last token of a run is accepted, the block raises a one-cycle job-start pulse so the datapath can begin, and then waits for the first token of the next run. A combinational read port lets the surrounding engine see any register. The pixel datapath, interpolation, coefficient tables and memory traffic are outside this block.

Top module: `warp_cmd_seq`

## Requirements
- R1: Bit 31 of a token selects its kind: 1 means configure, 0 means data. A configure token writes bits 24:0, zero-extended to 32 bits, to the register whose index is in bits 29:25. Bit 30 (run-type flag) has no effect on what is written.
- R2: A configure token whose index is 27 to 31 changes no register.
- R3: After reset every register reads 0, which selects scaling mode. `tok_ready` is 1 and `job_start` is 0.
- R4: In scaling mode (bit 0 of register 26 is 0), successive data tokens write bits 25:0, zero-extended, to register 4 (packed fractions: FRX in 9:0, IPX in 15:10, FRY in 25:16), then register 7 (source address), then register 11 (destination address).
- R5: In tetragon mode (bit 0 of register 26 is 1), ten data tokens fill registers 15, 16, 17, 18, 19, 20, 21, 22, 7, 11 in that order, each with bits 25:0.
- R6: `job_start` is 1 for exactly the one cycle after the last token of a run is accepted. `tok_ready` is 0 in that cycle, and at no other time.
- R7: A configure token accepted during a run is written at once. It neither restarts nor advances the run.
- R8: The mode is sampled when the first data token of a run is accepted. A change to register 26 during a run takes effect only from the next run.
- R9: Reading register 0 (check engine) always returns 0, even after it has been written.
- R10: `rd_data` shows register `rd_idx` in the same cycle. Indices 27 to 31 read 0. A write becomes visible in the cycle after its token is accepted.
- R11: After a run completes, the next data token goes to the first register of the run for the mode that is current at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token offered |
| tok_ready | output | 1 | Token can be taken this cycle |
| tok_data | input | 32 | Command or data token |
| rd_idx | input | 5 | Register read index |
| rd_data | output | 32 | Register read value |
| job_start | output | 1 | One-cycle pulse at the end of a run |

## Verification
The embedded assertions check several properties on every cycle: the start pulse never lasts two cycles, it follows only an accepted data token, configure tokens leave the run position untouched, the latched mode holds steady during a run, and the write port never addresses a register that does not exist. Only the bench's scenarios can show where each data token lands, the order of both runs, that out-of-range configure indices and the run-type flag leave every register unchanged, and that a mode change during a run is deferred. Those checks read the registers back through the read port after each token.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
    localparam int TOK_W      = 32;
    localparam int CMD_BIT    = 31;
    localparam int IDX_HI     = 29;
    localparam int IDX_LO     = 25;
    localparam int IDX_W      = IDX_HI - IDX_LO + 1;
    localparam int CFG_VAL_W  = 25;
    localparam int DAT_VAL_W  = 26;
    localparam int MODE_IDX   = 26;
    localparam int CE_IDX     = 0;
    localparam int SCALE_LEN  = 3;
    localparam int TETRA_LEN  = 10;
    localparam int STEP_W     = $clog2(TETRA_LEN);
    localparam int CORNER_CNT = 8;
    localparam int CORNER_IDX = 15;
    localparam int FRAC_IDX   = 4;
    localparam int SRC_IDX    = 7;
    localparam int DST_IDX    = 11;

    typedef struct packed {
        logic              is_cfg;
        logic [IDX_W-1:0]  idx;
        logic [CFG_VAL_W-1:0] cfg_val;
        logic [DAT_VAL_W-1:0] dat_val;
    } tok_fields_t;

    function automatic logic [IDX_W-1:0] run_target(input logic tetra,
                                                    input logic [STEP_W-1:0] step);
        logic [IDX_W-1:0] t;
        if (tetra) begin
            if (int'(step) < CORNER_CNT) t = IDX_W'(CORNER_IDX + int'(step));
            else if (int'(step) == CORNER_CNT) t = IDX_W'(SRC_IDX);
            else t = IDX_W'(DST_IDX);
        end else begin
            if (step == '0) t = IDX_W'(FRAC_IDX);
            else if (step == STEP_W'(1)) t = IDX_W'(SRC_IDX);
            else t = IDX_W'(DST_IDX);
        end
        return t;
    endfunction
endpackage

// File: rtl/wcs_tok_decode.sv
module wcs_tok_decode
    import wcs_pkg::*;
(
    input  logic [TOK_W-1:0] tok,
    output tok_fields_t      fields
);
    always_comb begin
        fields.is_cfg  = tok[CMD_BIT];
        fields.idx     = tok[IDX_HI:IDX_LO];
        fields.cfg_val = tok[CFG_VAL_W-1:0];
        fields.dat_val = tok[DAT_VAL_W-1:0];
    end
endmodule

// File: rtl/wcs_seq_steer.sv
module wcs_seq_steer
    import wcs_pkg::*;
#(
    parameter int NUM_REGS = 27,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  tok_fields_t       fields,
    input  logic              mode_bit,
    output logic              tok_ready,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_val,
    output logic              job_start
);
    localparam logic [STEP_W-1:0] SCALE_LAST = STEP_W'(SCALE_LEN - 1);
    localparam logic [STEP_W-1:0] TETRA_LAST = STEP_W'(TETRA_LEN - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              tetra;
        logic              start;
    } steer_t;

    steer_t st_d, st_q;
    logic   accept;
    logic   tetra_now;
    logic [STEP_W-1:0] last_step;

    assign accept    = tok_valid && !st_q.start;
    assign tok_ready = !st_q.start;
    assign job_start = st_q.start;

    always_comb begin
        st_d      = st_q;
        st_d.start = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = '0;
        wr_val    = '0;
        tetra_now = (st_q.step == '0) ? mode_bit : st_q.tetra;
        last_step = tetra_now ? TETRA_LAST : SCALE_LAST;
        if (accept) begin
            if (fields.is_cfg) begin
                if (int'(fields.idx) < NUM_REGS) begin
                    wr_en  = 1'b1;
                    wr_idx = fields.idx;
                    wr_val = DATA_W'(fields.cfg_val);
                end
            end else begin
                wr_en      = 1'b1;
                wr_idx     = run_target(tetra_now, st_q.step);
                wr_val     = DATA_W'(fields.dat_val);
                st_d.tetra = tetra_now;
                if (st_q.step == last_step) begin
                    st_d.step  = '0;
                    st_d.start = 1'b1;
                end else begin
                    st_d.step = st_q.step + STEP_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> !job_start);

    // R6
    start_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(job_start) |-> $past(tok_valid && tok_ready && !fields.is_cfg));

    // R7
    cfg_keeps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_ready && fields.is_cfg) |=> $stable(st_q.step));

    // R8
    mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.step != '0) |=> $stable(st_q.tetra));

    // R5
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.step) < TETRA_LEN);
endmodule

// File: rtl/wcs_regfile.sv
module wcs_regfile
    import wcs_pkg::*;
#(
    parameter int NUM_REGS = 27,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              mode_bit
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && int'(wr_idx) == g) regs_d[g] = wr_val;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (int'(rd_idx) == i && i != CE_IDX) rd_data = regs_q[i];
        end
    end

    assign mode_bit = regs_q[MODE_IDX][0];

    // R2
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_idx) < NUM_REGS);
endmodule

// File: rtl/warp_cmd_seq.sv
module warp_cmd_seq
    import wcs_pkg::*;
#(
    parameter int NUM_REGS = 27,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    output logic              tok_ready,
    input  logic [TOK_W-1:0]  tok_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              job_start
);
    tok_fields_t       fields;
    logic              mode_bit;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_val;

    wcs_tok_decode i_dec (
        .tok    (tok_data),
        .fields (fields)
    );

    wcs_seq_steer #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_valid (tok_valid),
        .fields    (fields),
        .mode_bit  (mode_bit),
        .tok_ready (tok_ready),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .job_start (job_start)
    );

    wcs_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) i_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .mode_bit (mode_bit)
    );

    // R9
    ce_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(CE_IDX)) |-> (rd_data == '0));
endmodule

// File: tb/test_warp_cmd_seq.sv
`timescale 1ns/1ps
module test_warp_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tok_valid = 1'b0;
    logic        tok_ready;
    logic [31:0] tok_data = '0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        job_start;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [31:0] model [27];
    logic obs_start, obs_ready;

    always #2.5 clk = ~clk;

    warp_cmd_seq i_warp_cmd_seq (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_data(tok_data), .rd_idx(rd_idx), .rd_data(rd_data), .job_start(job_start)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_fail++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [31:0] exp);
        rd_idx = 5'(idx);
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic all_chk(input string tag);
        for (int i = 0; i < 27; i++) rd_chk(tag, i, (i == 0) ? 32'h0 : model[i]);
        rd_chk(tag, 27, 32'h0);
        rd_chk(tag, 31, 32'h0);
    endtask

    task automatic send(input logic [31:0] t);
        tok_data  = t;
        tok_valid = 1'b1;
        while (!tok_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        tok_valid = 1'b0;
        obs_start = job_start;
        obs_ready = tok_ready;
    endtask

    function automatic logic [31:0] cfg_tok(input logic crun, input int idx, input logic [24:0] v);
        return {1'b1, crun, 5'(idx), v};
    endfunction

    function automatic int target(input logic tet, input int k);
        if (tet) return (k < 8) ? 15 + k : ((k == 8) ? 7 : 11);
        return (k == 0) ? 4 : ((k == 1) ? 7 : 11);
    endfunction

    task automatic send_cfg(input logic crun, input int idx, input logic [24:0] v);
        send(cfg_tok(crun, idx, v));
        if (idx < 27) model[idx] = {7'b0, v};
    endtask

    task automatic send_data(input logic tet, input int k, input logic [30:0] v);
        send({1'b0, v});
        model[target(tet, k)] = {6'b0, v[25:0]};
    endtask

    task automatic t_reset;
        chk("R3 ready", {31'b0, tok_ready}, 32'h1);
        chk("R3 start", {31'b0, job_start}, 32'h0);
        all_chk("R3 regs");
    endtask

    task automatic t_config;
        send_cfg(1'b1, 3, 25'h1ABCDEF);
        rd_chk("R1 crun=1 write", 3, 32'h01ABCDEF);
        rd_chk("R10 next cycle", 3, 32'h01ABCDEF);
        send_cfg(1'b0, 5, 25'h0F0F0F0);
        send_cfg(1'b0, 24, 25'h3);
        all_chk("R1 config");
    endtask

    task automatic t_ignore;
        send_cfg(1'b0, 27, 25'h1111111);
        send_cfg(1'b1, 31, 25'h1555555);
        send_cfg(1'b0, 28, 25'h0000001);
        rd_chk("R2 alias 11", 11, model[11]);
        rd_chk("R2 alias 15", 15, model[15]);
        all_chk("R2 ignored");
    endtask

    task automatic t_ce;
        send_cfg(1'b0, 0, 25'h1FFFFFF);
        rd_chk("R9 check engine", 0, 32'h0);
    endtask

    task automatic t_run(input logic tet, input logic [30:0] seed, input string tag);
        int len = tet ? 10 : 3;
        for (int k = 0; k < len; k++) begin
            send_data(tet, k, seed ^ 31'(k * 32'h0123457));
            if (k < len - 1) chk({tag, " no early start R6"}, {31'b0, obs_start}, 32'h0);
        end
        chk({tag, " start R6"}, {31'b0, obs_start}, 32'h1);
        chk({tag, " ready low R6"}, {31'b0, obs_ready}, 32'h0);
        @(negedge clk);
        chk({tag, " start one cycle R6"}, {31'b0, job_start}, 32'h0);
        chk({tag, " ready back R6"}, {31'b0, tok_ready}, 32'h1);
        all_chk(tag);
    endtask

    task automatic t_mid;
        send_cfg(1'b0, 26, 25'h1);
        for (int k = 0; k < 4; k++) send_data(1'b1, k, 31'h7C000000 | 31'(k + 32'h2A0));
        send_cfg(1'b0, 26, 25'h0);
        send_cfg(1'b1, 13, 25'h00ABCDE);
        rd_chk("R7 mid write", 13, 32'h000ABCDE);
        for (int k = 4; k < 10; k++) begin
            send_data(1'b1, k, 31'h03000000 | 31'(k + 32'h510));
            if (k < 9) chk("R7 R8 no restart", {31'b0, obs_start}, 32'h0);
        end
        chk("R8 tetragon kept start", {31'b0, obs_start}, 32'h1);
        all_chk("R8 tetragon kept");
        send_data(1'b0, 0, 31'h0155AA55);
        rd_chk("R11 first of next run", 4, 32'h0155AA55);
        send_data(1'b0, 1, 31'h00001000);
        send_data(1'b0, 2, 31'h00002000);
        chk("R11 scaling start", {31'b0, obs_start}, 32'h1);
        all_chk("R11 scaling after");
    endtask

    task automatic t_back_to_back;
        for (int k = 0; k < 3; k++) begin
            tok_data = {1'b0, 31'(32'h00300000 + k)};
            tok_valid = 1'b1;
            while (!tok_ready) @(negedge clk);
            @(posedge clk);
            model[target(1'b0, k)] = 32'h00300000 + k;
            @(negedge clk);
        end
        chk("R6 b2b start", {31'b0, job_start}, 32'h1);
        chk("R6 b2b stall", {31'b0, tok_ready}, 32'h0);
        tok_data = {1'b0, 31'h00000777};
        @(posedge clk);
        @(negedge clk);
        chk("R6 held token waits", {31'b0, job_start}, 32'h0);
        @(posedge clk);
        model[4] = 32'h777;
        @(negedge clk);
        tok_valid = 1'b0;
        all_chk("R11 b2b first");
        send_data(1'b0, 1, 31'h1);
        send_data(1'b0, 2, 31'h2);
        chk("R6 b2b finish", {31'b0, obs_start}, 32'h1);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 27; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_config;
        t_ignore;
        t_ce;
        t_run(1'b0, 31'h7FFFFFFF, "R4 scaling");
        t_run(1'b0, 31'h02345678, "R11 scaling again");
        send_cfg(1'b0, 26, 25'h1);
        t_run(1'b1, 31'h41234567, "R5 tetragon");
        t_mid;
        t_back_to_back;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule